// File: doc/BRIEF.md
# Wait-State SPI Master

This block is an SPI master that sits on a small register bus and uses bus wait states as its only flow control. Software or a sequencer writes a byte or a half-word to one of two transmit registers, and the block starts a full-duplex frame at once, most significant bit first. The frame can be 8 or 16 bits long. While the frame is on the wire, the block holds off any further register write by keeping `bus_ready` low. A read of a receive register is held until the last bit has been sampled. A program can therefore issue a transmit write and then a receive read, with no status polling between them.

The serial clock runs at the bus clock divided by 2*(DIV+1). Clock polarity and clock phase are programmable. MOSI can be forced to a fixed level through a control register. MISO is taken from one of 32 input lines, chosen by a 5-bit selector.

Two wait registers mark the end of the frame. The clock-wait register releases once SCLK has made its last edge. The data-wait register releases once the bit period that carries the LSB has finished. With phase 1 that point comes half an SCLK period later.

The sequencer is a three-state machine:

| State | Behaviour |
|-------|-----------|
| IDLE | No edges are generated. A transmit write moves it to RUN. |
| RUN | SCLK makes edges every DIV+1 cycles. After the final edge it moves to TAIL when phase is 1, or to IDLE when phase is 0. |
| TAIL | Waits out one half period, then returns to IDLE. |

Top module: `spim_stall_ctrl`

## Requirements
- R1: The configuration register is at word offset 0x00. Its DIV field is bits 7:2. Each SCLK level lasts DIV+1 clock cycles during a frame, and SCLK makes no edge outside a frame.
- R2: Configuration bit 0 sets the SCLK idle level. 0 means idle low and a rising first edge. 1 means idle high and a falling first edge.
- R3: Configuration bit 1 selects the phase. With 0, MISO is sampled on odd edges and MOSI changes on even edges, with the MSB presented before edge 1. With 1, MISO is sampled on even edges and MOSI changes on odd edges.
- R4: A write to 0x0C starts an 8-bit frame and a write to 0x10 starts a 16-bit frame, sending bits 7:0 or 15:0 MSB first. Afterwards, 0x18 reads the last 16 bits shifted in, and 0x14 reads the low 8 of them.
- R5: After a frame, MOSI holds the LSB that was sent.
- R6: A write to any register while a frame is active (RUN or TAIL) is held with `bus_ready` low until the frame has ended.
- R7: A read of 0x14 or 0x18 is held until the final bit has been sampled. When no frame is active it completes without wait.
- R8: A read of 0x1C is held until SCLK has no edges left. A read of 0x20 is held until the LSB bit period has ended, which is half a period later with phase 1. Both return 1.
- R9: A write to 0x08 drives MOSI to the value of bit 0.
- R10: Bits 4:0 at 0x04 select which of the 32 `miso_in` lines is sampled as MISO.
- R11: Reads of 0x00, 0x04 and the write-only registers never wait. Unused bits and write-only registers read 0. After reset the configuration, selector and receive data are 0, SCLK is low and MOSI is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request; held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 5:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Low while the current access is stalled |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso_in | input | 32 | Candidate MISO lines |

## Verification
A behavioural slave on the selected MISO line runs frames in all four polarity and phase combinations. It uses different patterns, divider values, line selections and both frame lengths. Patterns with unequal halves and asymmetric bits show whether the MSB-first order is kept in both directions, and a phase swap would corrupt both the received word and the captured word. The remaining checks are measured at the ports: the SCLK level length shows the divider, and wait-cycle counts separate the point where the clock-wait register releases from the point where the data-wait register releases. Forced-MOSI writes and masked reads show the direct-level path and that unused bits read 0.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_TAIL = 2'd2
    } seq_state_t;

    localparam logic [3:0] W_CFG   = 4'd0;
    localparam logic [3:0] W_MSEL  = 4'd1;
    localparam logic [3:0] W_MOSI  = 4'd2;
    localparam logic [3:0] W_TX8   = 4'd3;
    localparam logic [3:0] W_TX16  = 4'd4;
    localparam logic [3:0] W_RX8   = 4'd5;
    localparam logic [3:0] W_RX16  = 4'd6;
    localparam logic [3:0] W_CKWT  = 4'd7;
    localparam logic [3:0] W_DTWT  = 4'd8;
endpackage

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             len_full,
    input  logic [DIV_W-1:0] div,
    input  logic             pha,
    output seq_state_t       state,
    output logic             tog,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             lsb_done
);
    localparam int CNT_W = $clog2(2 * WORD_W + 1);
    localparam logic [CNT_W-1:0] EDGES_FULL = CNT_W'(2 * WORD_W);
    localparam logic [CNT_W-1:0] EDGES_HALF = CNT_W'(WORD_W);

    seq_state_t       state_d;
    logic [DIV_W-1:0] hcnt;
    logic [CNT_W-1:0] ecnt;
    logic [CNT_W-1:0] e_num;
    logic [CNT_W-1:0] total;
    logic             len_q;
    logic             edge_stb;
    logic             last_edge;

    assign total     = len_q ? EDGES_FULL : EDGES_HALF;
    assign e_num     = ecnt + 1'b1;
    assign edge_stb  = (state == S_RUN) && (hcnt == '0);
    assign last_edge = (e_num == total);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE: if (start) state_d = S_RUN;
            S_RUN:  if (edge_stb && last_edge) state_d = pha ? S_TAIL : S_IDLE;
            S_TAIL: if (hcnt == '0) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the sequencer: edge strobes
    always_comb begin
        sample_stb = edge_stb && (e_num[0] != pha);
        shift_stb  = edge_stb && (e_num[0] == pha) && !last_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt     <= '0;
            ecnt     <= '0;
            len_q    <= 1'b0;
            tog      <= 1'b0;
            lsb_done <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                hcnt     <= div;
                ecnt     <= '0;
                len_q    <= len_full;
                tog      <= 1'b0;
                lsb_done <= 1'b0;
            end else if (state != S_IDLE) begin
                if (hcnt == '0) hcnt <= div;
                else            hcnt <= hcnt - 1'b1;
                if (edge_stb) begin
                    ecnt <= e_num;
                    tog  <= ~tog;
                end
                if (sample_stb && (e_num >= total - 1'b1)) lsb_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              len_full,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              pha,
    input  logic              shift_stb,
    input  logic              sample_stb,
    input  logic              miso,
    input  logic              force_we,
    input  logic              force_val,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_data
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] aligned;

    assign aligned = len_full ? tx_data : {tx_data[HALF-1:0], {HALF{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_data <= '0;
            mosi    <= 1'b0;
        end else begin
            if (start) begin
                if (!pha) begin
                    mosi  <= aligned[WORD_W-1];
                    tx_sr <= aligned << 1;
                end else begin
                    tx_sr <= aligned;
                end
            end else if (force_we) begin
                mosi <= force_val;
            end else if (shift_stb) begin
                mosi  <= tx_sr[WORD_W-1];
                tx_sr <= tx_sr << 1;
            end
            if (sample_stb) rx_data <= {rx_data[WORD_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 6,
    parameter int SEL_W  = 5,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  seq_state_t        state,
    input  logic              lsb_done,
    input  logic [WORD_W-1:0] rx_data,
    output logic [DIV_W-1:0]  cfg_div,
    output logic              cfg_pha,
    output logic              cfg_pol,
    output logic              cfg_we,
    output logic [SEL_W-1:0]  miso_sel,
    output logic              start,
    output logic              len_full,
    output logic [WORD_W-1:0] tx_data,
    output logic              force_we,
    output logic              force_val
);
    localparam int HALF = WORD_W / 2;

    logic [3:0] word;
    logic       busy;
    logic       stall;
    logic       wr;

    assign word = bus_addr[5:2];
    assign busy = (state != S_IDLE);

    always_comb begin
        stall = 1'b0;
        if (bus_req) begin
            if (bus_we) stall = busy;
            else begin
                case (word)
                    W_RX8, W_RX16: stall = busy && !lsb_done;
                    W_CKWT:        stall = (state == S_RUN);
                    W_DTWT:        stall = busy;
                    default:       stall = 1'b0;
                endcase
            end
        end
    end

    assign bus_ready = !stall;
    assign wr        = bus_req && bus_we && !stall;
    assign cfg_we    = wr && (word == W_CFG);
    assign start     = wr && ((word == W_TX8) || (word == W_TX16));
    assign len_full  = (word == W_TX16);
    assign tx_data   = bus_wdata[WORD_W-1:0];
    assign force_we  = wr && (word == W_MOSI);
    assign force_val = bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div  <= '0;
            cfg_pha  <= 1'b0;
            cfg_pol  <= 1'b0;
            miso_sel <= '0;
        end else if (wr) begin
            if (word == W_CFG) begin
                cfg_div <= bus_wdata[DIV_W+1:2];
                cfg_pha <= bus_wdata[1];
                cfg_pol <= bus_wdata[0];
            end
            if (word == W_MSEL) miso_sel <= bus_wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_CFG:  bus_rdata[DIV_W+1:0] = {cfg_div, cfg_pha, cfg_pol};
            W_MSEL: bus_rdata[SEL_W-1:0] = miso_sel;
            W_RX8:  bus_rdata[HALF-1:0]  = rx_data[HALF-1:0];
            W_RX16: bus_rdata[WORD_W-1:0] = rx_data;
            W_CKWT, W_DTWT: bus_rdata[0] = 1'b1;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_stall_ctrl.sv
module spim_stall_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 6,
    parameter int N_IN   = 32,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              sclk,
    output logic              mosi,
    input  logic [N_IN-1:0]   miso_in
);
    localparam int SEL_W = $clog2(N_IN);

    seq_state_t        state;
    logic [DIV_W-1:0]  cfg_div;
    logic              cfg_pha;
    logic              cfg_pol;
    logic              cfg_we;
    logic [SEL_W-1:0]  miso_sel;
    logic              start;
    logic              len_full;
    logic [WORD_W-1:0] tx_data;
    logic              force_we;
    logic              force_val;
    logic              tog;
    logic              sample_stb;
    logic              shift_stb;
    logic              lsb_done;
    logic [WORD_W-1:0] rx_data;
    logic              miso;

    assign miso = miso_in[miso_sel];
    assign sclk = cfg_pol ^ tog;

    spim_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .SEL_W(SEL_W), .WORD_W(WORD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .state(state), .lsb_done(lsb_done), .rx_data(rx_data),
        .cfg_div(cfg_div), .cfg_pha(cfg_pha), .cfg_pol(cfg_pol), .cfg_we(cfg_we),
        .miso_sel(miso_sel), .start(start), .len_full(len_full), .tx_data(tx_data),
        .force_we(force_we), .force_val(force_val)
    );

    spim_seq #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len_full(len_full),
        .div(cfg_div), .pha(cfg_pha), .state(state), .tog(tog),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .lsb_done(lsb_done)
    );

    spim_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .len_full(len_full),
        .tx_data(tx_data), .pha(cfg_pha), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .miso(miso), .force_we(force_we),
        .force_val(force_val), .mosi(mosi), .rx_data(rx_data)
    );
endmodule

// File: rtl/spim_stall_ctrl_sva.sv
module spim_stall_ctrl_sva
    import spim_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_we,
    input logic [5:0] bus_addr,
    input logic       bus_ready,
    input logic       sclk,
    input logic       mosi,
    input seq_state_t state,
    input logic       cfg_pol,
    input logic       cfg_we
);
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (sclk == cfg_pol));

    assert_write_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && state != S_IDLE) |-> !bus_ready);

    assert_cfg_read_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[5:2] == 4'd0) |-> bus_ready);

    assert_lsb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TAIL) |=> $stable(mosi));

    assert_no_stray_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IDLE && state == S_IDLE && !$past(cfg_we)) |-> $stable(sclk));
endmodule

bind spim_stall_ctrl spim_stall_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ready(bus_ready), .sclk(sclk), .mosi(mosi),
    .state(state), .cfg_pol(cfg_pol), .cfg_we(cfg_we)
);

// File: tb/spim_stall_ctrl_tb.sv
module spim_stall_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        sclk;
    logic        mosi;
    logic [31:0] miso_in;

    int checks = 0;
    int failures = 0;

    // behavioural slave
    logic        s_on = 1'b0;
    logic        s_pol = 1'b0;
    logic        s_pha = 1'b0;
    logic [4:0]  s_sel = '0;
    logic [15:0] s_pat = '0;
    logic [15:0] s_rx = '0;
    int          s_idx = -1;
    logic        s_bit;

    always #5 clk = ~clk;

    spim_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .sclk(sclk), .mosi(mosi), .miso_in(miso_in)
    );

    assign s_bit = (s_idx >= 0 && s_idx < 16) ? s_pat[s_idx[3:0]] : 1'b0;

    always_comb begin
        miso_in = 32'h5A5A_A5A5;
        miso_in[s_sel] = s_bit;
    end

    always @(sclk) begin
        if (s_on) begin
            if ((sclk != s_pol) == !s_pha) s_rx = {s_rx[14:0], mosi};
            else s_idx = s_idx - 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic we, input logic [5:0] a, input logic [31:0] wd,
                            output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1; waits++;
        end
        rd = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int w;
        check(sclk == 1'b0, "R11 reset sclk", {31'b0, sclk}, 0);
        check(mosi == 1'b0, "R11 reset mosi", {31'b0, mosi}, 0);
        bus_xfer(0, 6'h00, 0, rd, w);
        check(rd == 0 && w == 0, "R11 reset cfg", rd, 0);
        bus_xfer(0, 6'h18, 0, rd, w);
        check(rd == 0 && w == 0, "R7 idle rx read no wait", rd, 0);
        bus_xfer(0, 6'h1C, 0, rd, w);
        check(rd == 1 && w == 0, "R8 clock-wait idle", rd, 1);
        bus_xfer(0, 6'h20, 0, rd, w);
        check(rd == 1 && w == 0, "R8 data-wait idle", rd, 1);
    endtask

    // full-duplex frame against the slave (R2 R3 R4 R5 R7 R10)
    task automatic t_mode(input logic pol, input logic pha, input logic full,
                          input logic [5:0] div, input logic [4:0] sel,
                          input logic [15:0] tx, input logic [15:0] pat);
        logic [31:0] rd; int w; int len; logic [15:0] mask;
        len  = full ? 16 : 8;
        mask = full ? 16'hFFFF : 16'h00FF;
        s_on = 1'b0;
        bus_xfer(1, 6'h00, {24'b0, div, pha, pol}, rd, w);
        bus_xfer(1, 6'h04, {27'b0, sel}, rd, w);
        s_pol = pol; s_pha = pha; s_sel = sel; s_pat = pat & mask; s_rx = '0;
        s_idx = pha ? len : len - 1;
        s_on = 1'b1;
        bus_xfer(1, full ? 6'h10 : 6'h0C, {16'b0, tx}, rd, w);
        bus_xfer(0, full ? 6'h18 : 6'h14, 0, rd, w);
        check(w > 0, "R7 rx read waited", w, 1);
        check(rd == {16'b0, pat & mask}, "R4 R3 R10 received word", rd, {16'b0, pat & mask});
        bus_xfer(0, 6'h20, 0, rd, w);
        check(rd == 1, "R8 data-wait returns 1", rd, 1);
        s_on = 1'b0;
        check((s_rx & mask) == (tx & mask), "R4 R3 sent MSB first", s_rx & mask, tx & mask);
        check(mosi == tx[0], "R5 mosi holds lsb", {31'b0, mosi}, {31'b0, tx[0]});
        check(sclk == pol, "R2 idle level", {31'b0, sclk}, {31'b0, pol});
    endtask

    task automatic t_divider();
        logic [31:0] rd; int w; int k; logic prev;
        bus_xfer(1, 6'h00, {24'b0, 6'd3, 2'b00}, rd, w);
        bus_xfer(1, 6'h0C, 32'hC3, rd, w);
        @(negedge clk); prev = sclk;
        while (sclk == prev) begin @(negedge clk); end
        prev = sclk; k = 0;
        while (sclk == prev) begin @(negedge clk); k++; end
        check(k == 4, "R1 half period DIV+1", k, 4);
        bus_xfer(0, 6'h20, 0, rd, w);
    endtask

    task automatic t_write_stall();
        logic [31:0] rd; int w;
        bus_xfer(1, 6'h00, {24'b0, 6'd3, 2'b00}, rd, w);
        bus_xfer(1, 6'h10, 32'h1234, rd, w);
        bus_xfer(1, 6'h08, 32'h1, rd, w);
        check(w > 60, "R6 write held for frame", w, 61);
        bus_xfer(0, 6'h20, 0, rd, w);
        check(w == 0, "R6 frame over when write lands", w, 0);
        check(mosi == 1'b1, "R9 forced high after frame", {31'b0, mosi}, 1);
    endtask

    task automatic t_mosi_ctl();
        logic [31:0] rd; int w;
        bus_xfer(1, 6'h08, 32'h0, rd, w);
        @(negedge clk);
        check(mosi == 1'b0, "R9 mosi low", {31'b0, mosi}, 0);
        bus_xfer(1, 6'h08, 32'hFFFF_FFFF, rd, w);
        @(negedge clk);
        check(mosi == 1'b1, "R9 mosi high", {31'b0, mosi}, 1);
    endtask

    task automatic t_idle_regs();
        logic [31:0] rd; int w;
        bus_xfer(1, 6'h00, {24'b0, 6'd2, 2'b10}, rd, w);
        bus_xfer(1, 6'h0C, 32'h5A, rd, w);
        bus_xfer(0, 6'h00, 0, rd, w);
        check(w == 0 && rd == 32'h0A, "R11 cfg read during frame", rd, 32'h0A);
        bus_xfer(0, 6'h1C, 0, rd, w);
        check(w > 0 && rd == 1, "R8 clock-wait held", w, 1);
        check(sclk == 1'b0, "R8 sclk idle at release", {31'b0, sclk}, 0);
        bus_xfer(0, 6'h20, 0, rd, w);
        check(w > 0 && rd == 1, "R8 data-wait later with phase 1", w, 1);
        bus_xfer(1, 6'h00, {24'b0, 6'd2, 2'b00}, rd, w);
        bus_xfer(1, 6'h0C, 32'h5A, rd, w);
        bus_xfer(0, 6'h1C, 0, rd, w);
        bus_xfer(0, 6'h20, 0, rd, w);
        check(w == 0, "R8 same release with phase 0", w, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] rd; int w;
        bus_xfer(1, 6'h00, 32'hFFFF_FFFF, rd, w);
        bus_xfer(0, 6'h00, 0, rd, w);
        check(rd == 32'hFF, "R11 cfg unused bits", rd, 32'hFF);
        bus_xfer(1, 6'h04, 32'hFFFF_FFFF, rd, w);
        bus_xfer(0, 6'h04, 0, rd, w);
        check(rd == 32'h1F && w == 0, "R11 selector unused bits", rd, 32'h1F);
        bus_xfer(0, 6'h0C, 0, rd, w);
        check(rd == 0 && w == 0, "R11 write-only reads 0", rd, 0);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mode(0, 0, 0, 6'd0, 5'd0,  16'h00B4, 16'h0069);
        t_mode(0, 1, 1, 6'd1, 5'd7,  16'hA1C3, 16'h3E71);
        t_mode(1, 0, 1, 6'd2, 5'd19, 16'h8001, 16'hF00D);
        t_mode(1, 1, 0, 6'd5, 5'd31, 16'h0037, 16'h00C8);
        t_divider();
        t_write_stall();
        t_mosi_ctl();
        t_idle_regs();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule